// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block schedules the work of a multi-channel analog-to-digital converter. It holds no analog circuitry. It decides which channel code to convert next, starts the converter with a one-cycle start strobe, and waits for the converter's done strobe. It then passes each result to a DMA-style consumer as a one-cycle valid pulse, together with the channel number. A sequence starts on one of four selectable events. The 4-bit last-channel setting and an 8-bit pin-enable mask choose which channels the sequence visits. A separately written one-off "extra" conversion runs at once when the block is idle, or directly after a running sequence ends.

Channel codes 0 to 7 are single-ended pins. Codes 8 to 11 are the pin pairs (0,1), (2,3), (4,5) and (6,7). Codes 12 to 15 are internal sources: ground, reference, temperature and supply/3. These internal sources have no pin. The converter returns a signed 16-bit value (positive input minus negative input), and the block forwards it unchanged. The block latches the reference and decimation settings into the converter-side outputs on each start strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `eoc`, `sw_start`, `conv_start`, `res_valid` and `seq_done` are all 0.
- R2: With a last-channel code below 8, a sequence converts the channels from 0 up to and including that code, in ascending order. It skips every channel whose bit in `pin_en` is 0 (bit n enables pin n).
- R3: With a code from 8 to 12, the sequence walks 8 up to the code. A pair code 8+k is converted only if both `pin_en[2k]` and `pin_en[2k+1]` are 1. Codes 12 to 15 need no pin.
- R4: With a code of 13 to 15, a sequence is exactly one conversion of that code, whatever `pin_en` holds.
- R5: `start_sel` picks the sequence trigger: 2'b00 a rising edge of `ext_pin`, 2'b01 a `seq_done` pulse, 2'b10 a `tmr_evt` pulse, 2'b11 the software start bit.
- R6: `sw_start_set` starts a sequence only when `start_sel` is 2'b11 and the block is idle. The bit `sw_start` reads 1 while that sequence runs and clears when the sequence ends. At any other time `sw_start_set` has no effect.
- R7: A trigger that arrives while `busy` is 1 is dropped and is not remembered.
- R8: An `xtra_wr` while the block is idle starts that conversion on the second clock edge after the write. An `xtra_wr` during a sequence runs after the last sequence conversion. Only one extra request is held, and a later write replaces an earlier pending one.
- R9: Each finished conversion gives one `res_valid` pulse, one cycle after `conv_done`. The pulse carries the converted code on `res_ch` and the converter's two's-complement value on `res_data`, unchanged.
- R10: `eoc` goes to 1 when any conversion finishes and to 0 on `rd_hi`. A finishing conversion wins over a read in the same cycle.
- R11: `seq_done` pulses for one cycle in the same cycle as the last sequence result. If no channel of the sequence is enabled, it pulses on the edge after the trigger, with no conversion.
- R12: `conv_ref` and `conv_dec` are captured on each start strobe. Changing `cfg_ref` or `cfg_dec` during a conversion does not alter that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_last_ch | input | 4 | Last channel code of a sequence |
| cfg_ref | input | REF_W | Reference select for sequence conversions |
| cfg_dec | input | DEC_W | Decimation select for sequence conversions |
| pin_en | input | 8 | Analog enable per input pin |
| start_sel | input | 2 | Sequence trigger source |
| sw_start_set | input | 1 | Software write of 1 to the start bit |
| ext_pin | input | 1 | External trigger pin (rising edge) |
| tmr_evt | input | 1 | Timer compare event pulse |
| xtra_wr | input | 1 | Write strobe of the extra-conversion setting |
| xtra_ch | input | 4 | Extra conversion channel code |
| xtra_ref | input | REF_W | Extra conversion reference select |
| xtra_dec | input | DEC_W | Extra conversion decimation select |
| rd_hi | input | 1 | Read of the result high byte |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | RES_W | Converter result |
| conv_start | output | 1 | Converter start strobe |
| conv_ch | output | 4 | Channel code of the running conversion |
| conv_ref | output | REF_W | Latched reference select |
| conv_dec | output | DEC_W | Latched decimation select |
| res_valid | output | 1 | Result valid pulse |
| res_ch | output | 4 | Channel of the presented result |
| res_data | output | RES_W | Presented result |
| eoc | output | 1 | End-of-conversion flag |
| sw_start | output | 1 | Software start bit |
| seq_done | output | 1 | End-of-sequence pulse |
| busy | output | 1 | A sequence or extra conversion is active |

## Verification
The bench aims at the channel walk. It uses sparse masks and half-enabled pairs, which would catch a design that converts a disabled pin or tests only one pin of a pair. It also uses codes at 12 and above, which would catch a design that walks from 0 or applies the mask to internal sources. It writes two extra requests during one sequence, which would catch a design that queues both or runs the first. It fires triggers while busy, which would catch a design that remembers them and starts a spurious sequence. It starts a sequence with no enabled channel, which would catch a design that hangs or never pulses `seq_done`. It changes the reference in the middle of a conversion, which would catch a design that passes the setting through instead of latching it. Chained mode would show up a design whose `seq_done` cannot restart the walk.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W = 16,
  parameter int REF_W = 2,
  parameter int DEC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cfg_last_ch,
  input  logic [REF_W-1:0] cfg_ref,
  input  logic [DEC_W-1:0] cfg_dec,
  input  logic [7:0]       pin_en,
  input  logic [1:0]       start_sel,
  input  logic             sw_start_set,
  input  logic             ext_pin,
  input  logic             tmr_evt,
  input  logic             xtra_wr,
  input  logic [3:0]       xtra_ch,
  input  logic [REF_W-1:0] xtra_ref,
  input  logic [DEC_W-1:0] xtra_dec,
  input  logic             rd_hi,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             conv_start,
  output logic [3:0]       conv_ch,
  output logic [REF_W-1:0] conv_ref,
  output logic [DEC_W-1:0] conv_dec,
  output logic             res_valid,
  output logic [3:0]       res_ch,
  output logic [RES_W-1:0] res_data,
  output logic             eoc,
  output logic             sw_start,
  output logic             seq_done,
  output logic             busy
);

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_XTRA} st_t;

  st_t              st;
  logic [3:0]       cur, last;
  logic             ext_q;
  logic             xp;
  logic [3:0]       xch;
  logic [REF_W-1:0] xref;
  logic [DEC_W-1:0] xdec;
  logic             trig;

  function automatic logic ch_ok(input logic [3:0] ch, input logic [7:0] m);
    if (!ch[3])        return m[ch[2:0]];
    else if (!ch[2])   return m[{ch[1:0], 1'b0}] & m[{ch[1:0], 1'b1}];
    else               return 1'b1;
  endfunction

  function automatic logic [4:0] find(input logic [4:0] lo, input logic [3:0] hi,
                                      input logic [7:0] m);
    logic [4:0] r;
    r = '0;
    for (int i = 15; i >= 0; i--)
      if (5'(i) >= lo && 4'(i) <= hi && ch_ok(4'(i), m)) r = {1'b1, 4'(i)};
    return r;
  endfunction

  wire ext_rise = ext_pin & ~ext_q;

  always_comb
    case (start_sel)
      2'b00:   trig = ext_rise;
      2'b01:   trig = seq_done;
      2'b10:   trig = tmr_evt;
      default: trig = sw_start_set;
    endcase

  wire [3:0] lo0 = (cfg_last_ch < 4'd8)  ? 4'd0 :
                   (cfg_last_ch <= 4'd12) ? 4'd8 : cfg_last_ch;
  wire [4:0] f_start = find({1'b0, lo0}, cfg_last_ch, pin_en);
  wire [4:0] f_next  = find({1'b0, cur} + 5'd1, last, pin_en);

  wire done_seq  = (st == S_SEQ) && conv_done;
  wire done_any  = (st != S_IDLE) && conv_done;
  wire start_seq = (st == S_IDLE) && !xp && trig;
  wire seq_end   = (start_seq && !f_start[4]) || (done_seq && !f_next[4]);
  wire go_x      = xp && ((st == S_IDLE) || seq_end);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur        <= '0;
      last       <= '0;
      ext_q      <= 1'b0;
      xp         <= 1'b0;
      xch        <= '0;
      xref       <= '0;
      xdec       <= '0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      conv_ref   <= '0;
      conv_dec   <= '0;
      res_valid  <= 1'b0;
      res_ch     <= '0;
      res_data   <= '0;
      eoc        <= 1'b0;
      sw_start   <= 1'b0;
      seq_done   <= 1'b0;
    end else begin
      ext_q      <= ext_pin;
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      seq_done   <= 1'b0;

      if (xtra_wr) begin
        xp   <= 1'b1;
        xch  <= xtra_ch;
        xref <= xtra_ref;
        xdec <= xtra_dec;
      end else if (go_x) begin
        xp <= 1'b0;
      end

      if (done_any) begin
        res_valid <= 1'b1;
        res_ch    <= conv_ch;
        res_data  <= conv_data;
        eoc       <= 1'b1;
      end else if (rd_hi) begin
        eoc <= 1'b0;
      end

      if (seq_end) begin
        seq_done <= 1'b1;
        sw_start <= 1'b0;
      end

      if (go_x) begin
        conv_start <= 1'b1;
        conv_ch    <= xch;
        conv_ref   <= xref;
        conv_dec   <= xdec;
        st         <= S_XTRA;
      end else if (start_seq && f_start[4]) begin
        conv_start <= 1'b1;
        conv_ch    <= f_start[3:0];
        conv_ref   <= cfg_ref;
        conv_dec   <= cfg_dec;
        cur        <= f_start[3:0];
        last       <= cfg_last_ch;
        sw_start   <= (start_sel == 2'b11);
        st         <= S_SEQ;
      end else if (done_seq && f_next[4]) begin
        conv_start <= 1'b1;
        conv_ch    <= f_next[3:0];
        conv_ref   <= cfg_ref;
        conv_dec   <= cfg_dec;
        cur        <= f_next[3:0];
      end else if (seq_end || ((st == S_XTRA) && conv_done)) begin
        st <= S_IDLE;
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic conv_done,
  input logic res_valid,
  input logic eoc,
  input logic rd_hi,
  input logic sw_start,
  input logic busy
);

  // R9
  res_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(conv_done) && $past(busy)));

  // R10
  eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> eoc);

  // R10
  eoc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !conv_done) |=> !eoc);

  // R6
  sw_bit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_start) |-> busy);

  // R7
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .res_valid(res_valid), .eoc(eoc), .rd_hi(rd_hi), .sw_start(sw_start),
  .busy(busy)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic [3:0] cfg_last_ch = 0;
  logic [1:0] cfg_ref = 0, cfg_dec = 0, start_sel = 2'b11;
  logic [7:0] pin_en = 8'hFF;
  logic sw_start_set = 0, ext_pin = 0, tmr_evt = 0, xtra_wr = 0, rd_hi = 0;
  logic [3:0] xtra_ch = 0;
  logic [1:0] xtra_ref = 0, xtra_dec = 0;
  logic conv_done = 0;
  logic [15:0] conv_data = 0;
  logic conv_start, res_valid, eoc, sw_start, seq_done, busy;
  logic [3:0] conv_ch, res_ch;
  logic [1:0] conv_ref, conv_dec;
  logic [15:0] res_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [19:0] exp_q[$];

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (.*);

  function automatic logic [15:0] model(logic [3:0] c, logic [1:0] r, logic [1:0] d);
    return {c, 4'h5, c, r, d};
  endfunction

  // converter stub
  int cnt = 0;
  logic [3:0] sc; logic [1:0] sr, sd;
  always @(posedge clk) begin
    conv_done <= 0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin conv_done <= 1; conv_data <= model(sc, sr, sd); end
    end
    if (conv_start === 1'b1) begin cnt <= LAT; sc <= conv_ch; sr <= conv_ref; sd <= conv_dec; end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && res_valid === 1'b1) begin
    if (exp_q.size() == 0) check("R7/R9 unexpected result", {res_ch, res_data}, 0);
    else begin
      logic [19:0] e;
      e = exp_q.pop_front();
      check("R9 result channel", res_ch, e[19:16]);
      check("R9 result data", res_data, e[15:0]);
    end
  end

  task automatic push_seq(logic [3:0] lc, logic [7:0] m, logic [1:0] r, logic [1:0] d);
    if (lc < 8) begin
      for (int c = 0; c <= lc; c++) if (m[c]) exp_q.push_back({4'(c), model(4'(c), r, d)});
    end else if (lc <= 12) begin
      for (int c = 8; c <= lc; c++)
        if (c == 12 || (m[2*(c-8)] && m[2*(c-8)+1])) exp_q.push_back({4'(c), model(4'(c), r, d)});
    end else exp_q.push_back({lc, model(lc, r, d)});
  endtask

  task automatic cfg(logic [3:0] lc, logic [7:0] m, logic [1:0] r, logic [1:0] d, logic [1:0] s);
    @(negedge clk);
    cfg_last_ch = lc; pin_en = m; cfg_ref = r; cfg_dec = d; start_sel = s;
  endtask

  task automatic sw_go();
    @(negedge clk) sw_start_set = 1;
    @(negedge clk) sw_start_set = 0;
  endtask

  task automatic wait_idle();
    do begin
      @(negedge clk);
      while (busy || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
    end while (busy);
  endtask

  task automatic wait_seq_done();
    do @(negedge clk); while (!seq_done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0); check("R1 eoc", eoc, 0); check("R1 sw_start", sw_start, 0);
    check("R1 conv_start", conv_start, 0); check("R1 res_valid", res_valid, 0);
    check("R1 seq_done", seq_done, 0);
    rst_n = 1;

    // R2 R6 R10 R11: software start, full walk
    cfg(4'd5, 8'hFF, 2'd1, 2'd2, 2'b11);
    push_seq(4'd5, 8'hFF, 2'd1, 2'd2);
    sw_go();
    check("R6 sw_start while running", sw_start, 1);
    wait_seq_done();
    check("R11 seq_done with last result", res_valid, 1);
    wait_idle();
    check("R6 sw_start cleared", sw_start, 0);
    check("R10 eoc set", eoc, 1);
    @(negedge clk) rd_hi = 1;
    @(negedge clk) rd_hi = 0;
    check("R10 eoc cleared by read", eoc, 0);

    // R2 sparse mask
    cfg(4'd7, 8'b1010_0101, 2'd2, 2'd0, 2'b11);
    push_seq(4'd7, 8'b1010_0101, 2'd2, 2'd0);
    sw_go(); wait_idle();

    // R3 pairs with half-enabled pairs
    cfg(4'd11, 8'b1100_0111, 2'd0, 2'd1, 2'b11);
    push_seq(4'd11, 8'b1100_0111, 2'd0, 2'd1);
    sw_go(); wait_idle();

    // R3 code 12 needs no pin
    cfg(4'd12, 8'h00, 2'd3, 2'd3, 2'b11);
    push_seq(4'd12, 8'h00, 2'd3, 2'd3);
    sw_go(); wait_idle();

    // R4 R5 R7 R12: timer start, single code 14, mid-conversion changes
    cfg(4'd14, 8'h00, 2'd0, 2'd0, 2'b10);
    push_seq(4'd14, 8'h00, 2'd0, 2'd0);
    @(negedge clk) tmr_evt = 1;
    @(negedge clk) tmr_evt = 0;
    check("R5 timer started", busy, 1);
    cfg_ref = 2'd3; cfg_dec = 2'd3;
    @(negedge clk) tmr_evt = 1;
    @(negedge clk) tmr_evt = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    check("R7 trigger during busy dropped", busy, 0);

    // R11 sequence with nothing enabled
    cfg(4'd3, 8'hF0, 2'd0, 2'd0, 2'b11);
    sw_go();
    check("R11 empty sequence seq_done", seq_done, 1);
    check("R11 empty sequence not busy", busy, 0);
    check("R6 empty sequence sw_start", sw_start, 0);

    // R5 external pin edge; level held high restarts nothing
    cfg(4'd2, 8'hFF, 2'd1, 2'd1, 2'b00);
    push_seq(4'd2, 8'hFF, 2'd1, 2'd1);
    @(negedge clk) ext_pin = 1;
    wait_idle();
    repeat (20) @(negedge clk);
    check("R5 ext level no restart", busy, 0);
    ext_pin = 0;

    // R8 two extra writes during a sequence: only the last runs, after the sequence
    cfg(4'd3, 8'hFF, 2'd0, 2'd2, 2'b11);
    push_seq(4'd3, 8'hFF, 2'd0, 2'd2);
    exp_q.push_back({4'd15, model(4'd15, 2'd2, 2'd3)});
    sw_go();
    @(negedge clk) begin xtra_wr = 1; xtra_ch = 4'd13; xtra_ref = 2'd0; xtra_dec = 2'd1; end
    @(negedge clk) begin xtra_ch = 4'd15; xtra_ref = 2'd2; xtra_dec = 2'd3; end
    @(negedge clk) xtra_wr = 0;
    wait_idle();
    repeat (20) @(negedge clk);

    // R8 extra at idle runs at once
    exp_q.push_back({4'd0, model(4'd0, 2'd1, 2'd1)});
    @(negedge clk) begin xtra_wr = 1; xtra_ch = 4'd0; xtra_ref = 2'd1; xtra_dec = 2'd1; end
    @(negedge clk) xtra_wr = 0;
    check("R8 extra pending not yet busy", busy, 0);
    @(negedge clk);
    check("R8 extra started from idle", busy, 1);
    wait_idle();

    // R5 chained start on seq_done
    cfg(4'd1, 8'hFF, 2'd3, 2'd0, 2'b11);
    push_seq(4'd1, 8'hFF, 2'd3, 2'd0);
    push_seq(4'd1, 8'hFF, 2'd3, 2'd0);
    sw_go();
    start_sel = 2'b01;
    wait_seq_done();
    @(negedge clk);
    check("R5 chained restart", busy, 1);
    start_sel = 2'b10;
    wait_idle();
    repeat (20) @(negedge clk);

    // R6 software bit ignored with another source selected
    cfg(4'd2, 8'hFF, 2'd0, 2'd0, 2'b10);
    sw_go();
    repeat (3) @(negedge clk);
    check("R6 sw start ignored busy", busy, 0);
    check("R6 sw start ignored bit", sw_start, 0);

    check("R9 all results arrived", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule